// File: doc/BRIEF.md
# Saturating Pipelined Population Counter

This block counts the set bits of a wide input word and reports the result as one of five classes: exactly zero, one, two or three bits set, or more than three. The word is cut into equal slices; each slice is counted on its own and its count saturated, the slice counts are registered, and a merge stage after that register sums them and saturates the total to the final class.

A word presented with its valid strobe high gives its class on the output one clock later, with the output valid strobe high in that same cycle. Typical use is a cheap "at most N errors" or "how many requests" check on a wide vector, where only small counts matter.

Top module: `sat_popcnt`

## Requirements
- R1: The input word is 40 bits wide and is handled as five 8-bit slices (slice k covers bits 8k+7 down to 8k).
- R2: The result class is encoded as 3'd0, 3'd1, 3'd2 or 3'd3 for exactly that many set bits, and 3'd4 when four or more bits are set.
- R3: An all-zeros word yields class 3'd0.
- R4: An all-ones word yields class 3'd4.
- R5: A word with exactly three set bits yields 3'd3, whether those bits share one slice or lie in different slices.
- R6: A word with exactly four set bits yields 3'd4, whether those bits share one slice or lie in different slices.
- R7: res_valid equals in_valid of the previous clock, and res_class is the class of the word presented in that previous clock.
- R8: A synchronous active-high reset clears res_valid in the cycle after it is sampled.
- R9: The result class never takes a code above 3'd4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is valid this cycle |
| in_word | input | 40 | Word whose set bits are counted |
| res_valid | output | 1 | Result valid, in_valid delayed one clock |
| res_class | output | 3 | Saturated count class, 0 to 4 |

## Verification
A stuck or wrong slice count register shows up on res_class in the very next cycle after a word whose set bits land in that slice, so words with bits placed in each slice in turn expose any single faulty slice. A saturation error appears only near the boundary of three and four bits, so those counts are driven both packed into one slice and spread across slices. A broken valid delay shows as res_valid disagreeing with the previous in_valid on the first clock after the change.

// File: rtl/sat_popcnt_pkg.sv
package sat_popcnt_pkg;
   localparam int unsigned SAT_LIMIT = 4;
   localparam int unsigned CODE_W    = $clog2(SAT_LIMIT + 1);
   typedef logic [CODE_W-1:0] sat_code_t;

   function automatic sat_code_t sat_add(input sat_code_t a, input sat_code_t b);
      int unsigned s;
      s = int'(a) + int'(b);
      if (s >= SAT_LIMIT) return sat_code_t'(SAT_LIMIT);
      return sat_code_t'(s);
   endfunction
endpackage

// File: rtl/slice_counter.sv
module slice_counter
   import sat_popcnt_pkg::*;
#(
   parameter int unsigned SLICE_W = 8
) (
   input  logic [SLICE_W-1:0] bits_i,
   output sat_code_t          code_o
);
   initial begin
      if (SLICE_W < 1) $error("SLICE_W must be at least 1");
   end

   always_comb begin
      code_o = '0;
      for (int i = 0; i < int'(SLICE_W); i++) begin
         code_o = sat_add(code_o, sat_code_t'(bits_i[i]));
      end
   end
endmodule

// File: rtl/class_merge.sv
module class_merge
   import sat_popcnt_pkg::*;
#(
   parameter int unsigned N_SLICES = 5
) (
   input  sat_code_t [N_SLICES-1:0] codes_i,
   output sat_code_t                class_o
);
   initial begin
      if (N_SLICES < 1) $error("N_SLICES must be at least 1");
   end

   always_comb begin
      class_o = '0;
      for (int k = 0; k < int'(N_SLICES); k++) begin
         class_o = sat_add(class_o, codes_i[k]);
      end
   end
endmodule

// File: rtl/sat_popcnt.sv
module sat_popcnt
   import sat_popcnt_pkg::*;
#(
   parameter int unsigned WORD_W  = 40,
   parameter int unsigned SLICE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   output logic              res_valid,
   output logic [2:0]        res_class
);
   localparam int unsigned N_SLICES = WORD_W / SLICE_W;

   initial begin
      if (WORD_W % SLICE_W != 0) $error("WORD_W must be a multiple of SLICE_W");
      if (CODE_W != 3) $error("result code must be 3 bits");
   end

   sat_code_t [N_SLICES-1:0] slice_code;
   sat_code_t [N_SLICES-1:0] slice_q;
   sat_code_t                merged;
   logic                     valid_q;

   // R1: one counter per slice
   for (genvar k = 0; k < int'(N_SLICES); k++) begin : g_slice
      slice_counter #(.SLICE_W(SLICE_W)) i_cnt (
         .bits_i (in_word[k*SLICE_W +: SLICE_W]),
         .code_o (slice_code[k])
      );
   end

   always_ff @(posedge clk) begin
      slice_q <= slice_code;
      if (rst) valid_q <= 1'b0;
      else     valid_q <= in_valid;
   end

   class_merge #(.N_SLICES(N_SLICES)) i_merge (
      .codes_i (slice_q),
      .class_o (merged)
   );

   assign res_valid = valid_q;
   assign res_class = merged;

   // R7
   valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> res_valid == $past(in_valid));
   // R8
   reset_clear_chk: assert property (@(posedge clk) rst |=> !res_valid);
   // R9
   class_range_chk: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> res_class <= 3'd4);
   // R3
   zero_word_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_word == '0) |=> res_class == 3'd0);
   // R4
   ones_word_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && &in_word) |=> res_class == 3'd4);
endmodule

// File: tb/test_sat_popcnt.sv
module test_sat_popcnt;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [39:0] in_word;
   logic        res_valid;
   logic [2:0]  res_class;

   int checks = 0;
   int errors = 0;
   logic        exp_valid;
   logic [2:0]  exp_class;

   always #2.5 clk = ~clk;

   sat_popcnt i_sat_popcnt (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
      .res_valid(res_valid), .res_class(res_class)
   );

   function automatic logic [2:0] ref_class(input logic [39:0] w);
      int n = 0;
      for (int i = 0; i < 40; i++) n += int'(w[i]);
      return (n > 3) ? 3'd4 : 3'(n);
   endfunction

   task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // apply a word, then sample the result after the next edge
   task automatic apply(input string req, input logic v, input logic [39:0] w);
      in_valid = v;
      in_word  = w;
      exp_valid = v;
      exp_class = ref_class(w);
      @(posedge clk); #1;
      check({req, "/R7 valid"}, {2'b0, res_valid}, {2'b0, exp_valid});
      check(req, res_class, exp_class);
   endtask

   initial begin
      #50000;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; in_valid = 1'b1; in_word = '1;
      @(posedge clk); #1;
      check("R8 reset", {2'b0, res_valid}, 3'd0);
      @(negedge clk); rst = 1'b0;
      apply("R3 zeros", 1'b1, 40'h0);
      apply("R4 ones", 1'b1, {40{1'b1}});
      apply("R5 three one slice", 1'b1, 40'h00_0000_0700);
      apply("R5 three spread", 1'b1, 40'h01_0001_0001);
      apply("R6 four one slice", 1'b1, 40'h00_F000_0000);
      apply("R6 four spread", 1'b1, 40'h80_0100_8001);
      apply("R1 slice4 two", 1'b1, 40'h81_0000_0000);
      apply("R2 single", 1'b1, 40'h00_0000_0010);
      apply("R7 idle", 1'b0, 40'h0);
      for (int k = 0; k < 5; k++)
         apply("R1 per slice", 1'b1, 40'h7 << (8*k));
      for (int j = 0; j < 200; j++) begin
         logic [39:0] w;
         w = {$urandom, $urandom};
         if (j % 2 == 0) w = w & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         apply("R9 random", 1'($urandom), w);
      end
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      check("R8 reset again", {2'b0, res_valid}, 3'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule